// File: doc/BRIEF.md
# Binary Order-Entry Session Sequencer

This block manages one binary order-entry session that runs over a TCP byte stream that is already open. When told to start, it brings the session up in four steps. It emits a Negotiate message and waits for the negotiation response. It then emits an Establish message and waits for the establishment acknowledgement. Once the session is up, it turns quote-side requests into new-order and cancel messages. It numbers these application messages in sequence, and it fills quiet periods on the line with heartbeats.

The block never handles bytes. Its inputs are inbound message types that an upstream receiver has already decoded, plus new-order and cancel requests that each carry an order identifier. Its output is a registered message descriptor (type, sequence number, order identifier) that a downstream frame serializer consumes, one per cycle. A handshake step that gets no reply within a fixed cycle budget sends the session back to idle and raises an error flag. That flag stays up until the next start.

Top module: `fixp_session_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_valid_o`, `established_o`, `session_error_o`, `new_ack_o` and `cancel_ack_o` are all 0.
- R2: A `start_i` pulse while idle causes a descriptor on the next clock edge with `tx_type_o` = 1 (Negotiate) and `tx_seq_o` = 0.
- R3: While the block waits for the negotiation response, an inbound `rx_type_i` = 1 causes a descriptor on the next edge with `tx_type_o` = 2 (Establish). Any other inbound code in that state produces no descriptor and no state change.
- R4: While the block waits for the acknowledgement, an inbound `rx_type_i` = 2 raises `established_o` on the next edge, and no descriptor is emitted on that edge.
- R5: Before `established_o` is high, new-order and cancel requests are never acknowledged and never produce a descriptor.
- R6: Once established, an accepted request is acknowledged combinationally in the same cycle. It produces a descriptor on the next edge: `tx_type_o` = 4 (new order) or 5 (cancel), with the request's identifier on `tx_id_o`. Sequence numbers start at 1 after establishment and rise by one with each order or cancel descriptor.
- R7: When a new-order request and a cancel request are both present in the same cycle, only the cancel is acknowledged and sent. The new order stays pending.
- R8: Once established with `keepalive_i` = K > 0, a heartbeat (`tx_type_o` = 3) is emitted exactly K clock edges after the latest descriptor or after establishment. Its `tx_seq_o` is the next unused sequence number, and that number is not consumed.
- R9: While `keepalive_i` = 0, no heartbeat is emitted.
- R10: If no expected reply arrives within TIMEOUT_CYC edges after a Negotiate or Establish descriptor, the block returns to idle and raises `session_error_o` exactly on that edge. The next start clears the flag.
- R11: `start_i` has no effect while the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| keepalive_i | input | KA_W | Idle cycles before a heartbeat; 0 disables heartbeats |
| start_i | input | 1 | Begin the session handshake |
| rx_valid_i | input | 1 | An inbound decoded message is present |
| rx_type_i | input | 2 | Inbound code: 1 negotiation response, 2 establishment ack, others ignored |
| new_req_i | input | 1 | New-order request |
| new_id_i | input | ID_W | Identifier of the new order |
| cancel_req_i | input | 1 | Cancel request |
| cancel_id_i | input | ID_W | Identifier of the order to cancel |
| new_ack_o | output | 1 | New-order request taken this cycle |
| cancel_ack_o | output | 1 | Cancel request taken this cycle |
| tx_valid_o | output | 1 | Descriptor valid |
| tx_type_o | output | 3 | Message kind: 1 Negotiate, 2 Establish, 3 heartbeat, 4 new order, 5 cancel |
| tx_seq_o | output | SEQ_W | Sequence number carried by the descriptor |
| tx_id_o | output | ID_W | Order identifier (orders and cancels only) |
| established_o | output | 1 | Session is up |
| session_error_o | output | 1 | Last handshake timed out |

## Verification
Request acknowledgements come from combinational logic and are sampled mid-cycle, before the edge that takes the request. Every descriptor and every flag change appears one edge after the stimulus that caused it, and the bench samples each one a nanosecond after that edge. The two timed results, a heartbeat due K edges after the last descriptor and a timeout due TIMEOUT_CYC edges after a handshake message, are found by counting edges from that reference edge and recording the first edge where the output appears. The recorded count must equal the interval exactly, so a result one cycle early or late fails the check.

// File: rtl/fixp_sess_pkg.sv
package fixp_sess_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_NEG = 2'd1,
        ST_WAIT_EST = 2'd2,
        ST_UP       = 2'd3
    } sess_state_e;

    typedef enum logic [2:0] {
        MSG_NONE      = 3'd0,
        MSG_NEGOTIATE = 3'd1,
        MSG_ESTABLISH = 3'd2,
        MSG_HEARTBEAT = 3'd3,
        MSG_NEW_ORDER = 3'd4,
        MSG_CANCEL    = 3'd5
    } tx_msg_e;

    localparam logic [1:0] RX_NEG_RESP = 2'd1;
    localparam logic [1:0] RX_EST_ACK  = 2'd2;

endpackage

// File: rtl/fixp_interval_cnt.sv
// Saturating cycle counter with a programmable expiry threshold.
module fixp_interval_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (cnt_q != '1) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Expires on the cycle whose edge completes limit_i counted cycles.
    assign hit_o = (limit_i != '0) && (cnt_q >= (limit_i - W'(1)));

endmodule

// File: rtl/fixp_order_arb.sv
// Picks one application request per cycle; cancels outrank new orders.
module fixp_order_arb
    import fixp_sess_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic            enable_i,
    input  logic            new_req_i,
    input  logic [ID_W-1:0] new_id_i,
    input  logic            cxl_req_i,
    input  logic [ID_W-1:0] cxl_id_i,
    output logic            grant_new_o,
    output logic            grant_cxl_o,
    output logic            pick_valid_o,
    output tx_msg_e         pick_type_o,
    output logic [ID_W-1:0] pick_id_o
);

    always_comb begin
        grant_cxl_o  = enable_i && cxl_req_i;
        grant_new_o  = enable_i && new_req_i && !cxl_req_i;
        pick_valid_o = grant_cxl_o || grant_new_o;
        pick_type_o  = grant_cxl_o ? MSG_CANCEL : MSG_NEW_ORDER;
        pick_id_o    = grant_cxl_o ? cxl_id_i : new_id_i;
    end

endmodule

// File: rtl/fixp_session_seq.sv
module fixp_session_seq
    import fixp_sess_pkg::*;
#(
    parameter int ID_W        = 16,
    parameter int SEQ_W       = 32,
    parameter int KA_W        = 16,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KA_W-1:0]  keepalive_i,
    input  logic             start_i,
    input  logic             rx_valid_i,
    input  logic [1:0]       rx_type_i,
    input  logic             new_req_i,
    input  logic [ID_W-1:0]  new_id_i,
    input  logic             cancel_req_i,
    input  logic [ID_W-1:0]  cancel_id_i,
    output logic             new_ack_o,
    output logic             cancel_ack_o,
    output logic             tx_valid_o,
    output logic [2:0]       tx_type_o,
    output logic [SEQ_W-1:0] tx_seq_o,
    output logic [ID_W-1:0]  tx_id_o,
    output logic             established_o,
    output logic             session_error_o
);

    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
    localparam int CNT_W = (KA_W > TMO_W) ? KA_W : TMO_W;

    typedef struct packed {
        sess_state_e      st;
        logic [SEQ_W-1:0] seq;
        logic             tx_valid;
        tx_msg_e          tx_type;
        logic [SEQ_W-1:0] tx_seq;
        logic [ID_W-1:0]  tx_id;
        logic             err;
    } regs_t;

    localparam regs_t RST_VAL = '0;

    regs_t d, q;

    sess_state_e      state_q;
    logic             up;
    logic             pick_valid;
    tx_msg_e          pick_type;
    logic [ID_W-1:0]  pick_id;
    logic             cnt_clear;
    logic [CNT_W-1:0] cnt_limit;
    logic             cnt_hit;
    logic             rx_neg, rx_ack;

    assign state_q = q.st;
    assign up      = (q.st == ST_UP);
    assign rx_neg  = rx_valid_i && (rx_type_i == RX_NEG_RESP);
    assign rx_ack  = rx_valid_i && (rx_type_i == RX_EST_ACK);

    fixp_order_arb #(.ID_W(ID_W)) i_arb (
        .enable_i     (up),
        .new_req_i    (new_req_i),
        .new_id_i     (new_id_i),
        .cxl_req_i    (cancel_req_i),
        .cxl_id_i     (cancel_id_i),
        .grant_new_o  (new_ack_o),
        .grant_cxl_o  (cancel_ack_o),
        .pick_valid_o (pick_valid),
        .pick_type_o  (pick_type),
        .pick_id_o    (pick_id)
    );

    // One counter serves both the reply timeout and the keepalive interval;
    // the two windows never overlap in time.
    assign cnt_limit = up ? CNT_W'(keepalive_i) : CNT_W'(TIMEOUT_CYC);

    fixp_interval_cnt #(.W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .limit_i (cnt_limit),
        .hit_o   (cnt_hit)
    );

    always_comb begin
        d          = q;
        d.tx_valid = 1'b0;
        d.tx_type  = MSG_NONE;
        d.tx_seq   = '0;
        d.tx_id    = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_WAIT_NEG;
                    d.err      = 1'b0;
                    d.tx_valid = 1'b1;
                    d.tx_type  = MSG_NEGOTIATE;
                end
            end
            ST_WAIT_NEG: begin
                if (rx_neg) begin
                    d.st       = ST_WAIT_EST;
                    d.tx_valid = 1'b1;
                    d.tx_type  = MSG_ESTABLISH;
                end else if (cnt_hit) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end
            end
            ST_WAIT_EST: begin
                if (rx_ack) begin
                    d.st  = ST_UP;
                    d.seq = SEQ_W'(1);
                end else if (cnt_hit) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end
            end
            ST_UP: begin
                if (pick_valid) begin
                    d.tx_valid = 1'b1;
                    d.tx_type  = pick_type;
                    d.tx_id    = pick_id;
                    d.tx_seq   = q.seq;
                    d.seq      = q.seq + SEQ_W'(1);
                end else if (cnt_hit) begin
                    d.tx_valid = 1'b1;
                    d.tx_type  = MSG_HEARTBEAT;
                    d.tx_seq   = q.seq;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    assign cnt_clear = (q.st == ST_IDLE) || (d.st != q.st) || d.tx_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign tx_valid_o      = q.tx_valid;
    assign tx_type_o       = q.tx_type;
    assign tx_seq_o        = q.tx_seq;
    assign tx_id_o         = q.tx_id;
    assign established_o   = up;
    assign session_error_o = q.err;

endmodule

// File: rtl/fixp_session_seq_chk.sv
module fixp_session_seq_chk
    import fixp_sess_pkg::*;
#(
    parameter int SEQ_W = 32,
    parameter int KA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             new_req_i,
    input logic             cancel_req_i,
    input logic             new_ack_o,
    input logic             cancel_ack_o,
    input logic             tx_valid_o,
    input logic [2:0]       tx_type_o,
    input logic [SEQ_W-1:0] tx_seq_o,
    input logic             established_o,
    input logic             session_error_o,
    input logic [KA_W-1:0]  keepalive_i,
    input sess_state_e      state_q
);

    // R2
    start_negotiate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (tx_valid_o && tx_type_o == MSG_NEGOTIATE));

    // R4
    est_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(established_o) |-> !tx_valid_o);

    // R5
    order_needs_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && (tx_type_o == MSG_NEW_ORDER || tx_type_o == MSG_CANCEL)) |-> established_o);

    // R5
    no_ack_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !established_o |-> !(new_ack_o || cancel_ack_o));

    // R6
    order_seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && (tx_type_o == MSG_NEW_ORDER || tx_type_o == MSG_CANCEL)) |-> tx_seq_o != '0);

    // R7
    cancel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_req_i && cancel_req_i) |-> !new_ack_o);

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({new_ack_o, cancel_ack_o}));

    // R9
    hb_needs_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_type_o == MSG_HEARTBEAT) |-> $past(keepalive_i) != '0);

    // R10
    error_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(session_error_o) |-> (state_q == ST_IDLE && !established_o));

endmodule

bind fixp_session_seq fixp_session_seq_chk #(.SEQ_W(SEQ_W), .KA_W(KA_W)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .new_req_i       (new_req_i),
    .cancel_req_i    (cancel_req_i),
    .new_ack_o       (new_ack_o),
    .cancel_ack_o    (cancel_ack_o),
    .tx_valid_o      (tx_valid_o),
    .tx_type_o       (tx_type_o),
    .tx_seq_o        (tx_seq_o),
    .established_o   (established_o),
    .session_error_o (session_error_o),
    .keepalive_i     (keepalive_i),
    .state_q         (state_q)
);

// File: tb/test_fixp_session_seq.sv
`timescale 1ns/1ps
module test_fixp_session_seq;

    localparam int ID_W  = 16;
    localparam int SEQ_W = 32;
    localparam int KA_W  = 16;
    localparam int TMO   = 40;
    localparam int HB_K  = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [KA_W-1:0]  keepalive_i;
    logic             start_i;
    logic             rx_valid_i;
    logic [1:0]       rx_type_i;
    logic             new_req_i;
    logic [ID_W-1:0]  new_id_i;
    logic             cancel_req_i;
    logic [ID_W-1:0]  cancel_id_i;
    logic             new_ack_o, cancel_ack_o;
    logic             tx_valid_o;
    logic [2:0]       tx_type_o;
    logic [SEQ_W-1:0] tx_seq_o;
    logic [ID_W-1:0]  tx_id_o;
    logic             established_o, session_error_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fixp_session_seq #(.ID_W(ID_W), .SEQ_W(SEQ_W), .KA_W(KA_W), .TIMEOUT_CYC(TMO)) i_fixp_session_seq (
        .clk(clk), .rst_n(rst_n), .keepalive_i(keepalive_i), .start_i(start_i),
        .rx_valid_i(rx_valid_i), .rx_type_i(rx_type_i),
        .new_req_i(new_req_i), .new_id_i(new_id_i),
        .cancel_req_i(cancel_req_i), .cancel_id_i(cancel_id_i),
        .new_ack_o(new_ack_o), .cancel_ack_o(cancel_ack_o),
        .tx_valid_o(tx_valid_o), .tx_type_o(tx_type_o), .tx_seq_o(tx_seq_o), .tx_id_o(tx_id_o),
        .established_o(established_o), .session_error_o(session_error_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; keepalive_i = '0; start_i = 1'b0; rx_valid_i = 1'b0; rx_type_i = '0;
        new_req_i = 1'b0; new_id_i = '0; cancel_req_i = 1'b0; cancel_id_i = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "tx_valid in reset", tx_valid_o, 0);
        chk("R1", "established in reset", established_o, 0);
        chk("R1", "error in reset", session_error_o, 0);
        @(negedge clk) rst_n = 1'b1;
        tick();
        chk("R1", "tx_valid after reset", tx_valid_o, 0);
        chk("R1", "acks after reset", {new_ack_o, cancel_ack_o}, 0);
    endtask

    task automatic t_orders_while_down();
        @(negedge clk);
        new_req_i = 1'b1; new_id_i = 16'h0aa1; cancel_req_i = 1'b1; cancel_id_i = 16'h0aa2;
        #1;
        chk("R5", "acks while idle", {new_ack_o, cancel_ack_o}, 0);
        tick();
        chk("R5", "no tx while idle", tx_valid_o, 0);
        tick();
        chk("R5", "still no tx", tx_valid_o, 0);
        @(negedge clk);
        new_req_i = 1'b0; cancel_req_i = 1'b0;
    endtask

    task automatic t_timeout();
        int first = 0;
        @(negedge clk) start_i = 1'b1;
        tick();
        chk("R2", "negotiate valid", tx_valid_o, 1);
        chk("R2", "negotiate type", tx_type_o, 1);
        chk("R2", "negotiate seq", tx_seq_o, 0);
        @(negedge clk) start_i = 1'b0;
        for (int i = 1; i <= TMO + 3; i++) begin
            @(posedge clk);
            #1;
            if (session_error_o && first == 0) first = i;
        end
        chk("R10", "timeout edge count", first, TMO);
        chk("R10", "not established after timeout", established_o, 0);
        // Back in idle: orders remain refused.
        @(negedge clk) new_req_i = 1'b1;
        #1;
        chk("R5", "ack after timeout", new_ack_o, 0);
        @(negedge clk) new_req_i = 1'b0;
    endtask

    task automatic t_handshake();
        @(negedge clk) start_i = 1'b1;
        tick();
        chk("R2", "negotiate on restart", tx_type_o, 1);
        chk("R10", "error cleared on start", session_error_o, 0);
        @(negedge clk) begin
            start_i = 1'b0; rx_valid_i = 1'b1; rx_type_i = 2'd2;
        end
        tick();
        chk("R3", "early ack ignored tx", tx_valid_o, 0);
        chk("R3", "early ack ignored state", established_o, 0);
        @(negedge clk) rx_type_i = 2'd3;
        tick();
        chk("R3", "unknown code ignored", tx_valid_o, 0);
        @(negedge clk) rx_type_i = 2'd1;
        tick();
        chk("R3", "establish valid", tx_valid_o, 1);
        chk("R3", "establish type", tx_type_o, 2);
        @(negedge clk) rx_type_i = 2'd2;
        tick();
        chk("R4", "established", established_o, 1);
        chk("R4", "no tx on establish", tx_valid_o, 0);
        @(negedge clk) rx_valid_i = 1'b0;
    endtask

    task automatic t_start_ignored();
        @(negedge clk) start_i = 1'b1;
        tick();
        chk("R11", "start while up no tx", tx_valid_o, 0);
        chk("R11", "start while up keeps session", established_o, 1);
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic t_orders();
        @(negedge clk) begin new_req_i = 1'b1; new_id_i = 16'h0111; end
        #1;
        chk("R6", "new ack", new_ack_o, 1);
        tick();
        chk("R6", "new type", tx_type_o, 4);
        chk("R6", "first seq", tx_seq_o, 1);
        chk("R6", "new id", tx_id_o, 16'h0111);
        @(negedge clk) new_id_i = 16'h0222;
        tick();
        chk("R6", "second seq", tx_seq_o, 2);
        chk("R6", "second id", tx_id_o, 16'h0222);
        @(negedge clk) begin new_req_i = 1'b0; cancel_req_i = 1'b1; cancel_id_i = 16'h0333; end
        #1;
        chk("R6", "cancel ack", cancel_ack_o, 1);
        tick();
        chk("R6", "cancel type", tx_type_o, 5);
        chk("R6", "cancel seq", tx_seq_o, 3);
        chk("R6", "cancel id", tx_id_o, 16'h0333);
        @(negedge clk) cancel_req_i = 1'b0;
        tick();
        chk("R6", "idle gap no tx", tx_valid_o, 0);
    endtask

    task automatic t_priority();
        @(negedge clk) begin
            new_req_i = 1'b1; new_id_i = 16'h0444; cancel_req_i = 1'b1; cancel_id_i = 16'h0555;
        end
        #1;
        chk("R7", "cancel acked", cancel_ack_o, 1);
        chk("R7", "new held off", new_ack_o, 0);
        tick();
        chk("R7", "cancel first type", tx_type_o, 5);
        chk("R7", "cancel first id", tx_id_o, 16'h0555);
        chk("R7", "cancel first seq", tx_seq_o, 4);
        @(negedge clk) cancel_req_i = 1'b0;
        #1;
        chk("R7", "new acked next", new_ack_o, 1);
        tick();
        chk("R7", "new follows type", tx_type_o, 4);
        chk("R7", "new follows seq", tx_seq_o, 5);
        @(negedge clk) new_req_i = 1'b0;
    endtask

    task automatic t_heartbeat();
        int first = 0;
        int second = 0;
        logic [2:0] hb_type = '0;
        logic [SEQ_W-1:0] hb_seq = '0;
        keepalive_i = KA_W'(HB_K);
        for (int i = 1; i <= 2 * HB_K + 1; i++) begin
            @(posedge clk);
            #1;
            if (tx_valid_o) begin
                if (first == 0) begin
                    first = i; hb_type = tx_type_o; hb_seq = tx_seq_o;
                end else if (second == 0) begin
                    second = i;
                end
            end
        end
        chk("R8", "heartbeat edge", first, HB_K);
        chk("R8", "heartbeat type", hb_type, 3);
        chk("R8", "heartbeat seq", hb_seq, 6);
        chk("R8", "second heartbeat edge", second, 2 * HB_K);
        @(negedge clk) begin new_req_i = 1'b1; new_id_i = 16'h0666; end
        tick();
        chk("R8", "seq not consumed", tx_seq_o, 6);
        @(negedge clk) begin new_req_i = 1'b0; keepalive_i = '0; end
    endtask

    task automatic t_ka_off();
        int seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1;
            if (tx_valid_o) seen++;
        end
        chk("R9", "no heartbeat when disabled", seen, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_orders_while_down();
        t_timeout();
        t_handshake();
        t_start_ignored();
        t_orders();
        t_priority();
        t_heartbeat();
        t_ka_off();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule